// File: doc/BRIEF.md
# Random Word Generator Controller

This block is a register-mapped controller for a pseudo-random word source. Software reaches it over a simple 32-bit register bus. Each access is a single cycle: a select strobe, a write flag, a byte address and write data. From the bus, software can do the following:

- read a fixed identification word;
- issue commands;
- set interrupt masks and an auto-seed flag;
- poll a status word;
- pull random words from a data port.

Two long-running operations, seeding and self-test, each step through idle, running and done. While an operation is running it holds the block busy for a fixed number of clock cycles. When it finishes, it raises a level interrupt unless done-interrupts are masked.

The random words come from an internal maximal-length LFSR. Each read of the data port returns the current LFSR value and advances the LFSR by exactly one step. The output-buffer fields in the status word always describe a full 5-word buffer, and a fresh seed is always reported as available. No error or test-failure condition is ever reported.

Read data is registered. It appears on `bus_rdata` on the clock edge that accepts the read, and it holds until the next read.

Top module: `rng_ctl_top`

## Requirements
- R1: After the synchronous reset, the following hold. `irq` and `bus_rdata` are 0. The command word (byte offset 0x04) reads 0. The control word (0x08) reads 0. The status word (0x0C) reads 0x0000_5541. Read data appears on `bus_rdata` at the edge that samples `bus_sel`=1 with `bus_wr`=0.
- R2: The identification word at offset 0x00 reads 0x1000_0240: type 1 in bits 31:28, major 0x2 in bits 15:8 and minor 0x40 in bits 7:0.
- R3: A write to control (0x08) replaces three bits. Bit 6 masks errors, bit 5 masks done-interrupts and bit 4 enables auto-seed. Those bits read back as written, and every other control bit reads 0.
- R4: A command write with bit 1 starts seeding, and one with bit 0 starts self-test. The operation runs for RUN_CYCLES cycles (default 16) after the write edge and then reaches done. While it runs, command bit 1 (seed) or bit 0 (self-test) reads 1, status bit 1 (busy) is 1 and status bit 0 (ready) is 0. Once it is done, status bit 5 (seed) or bit 4 (self-test) reads 1.
- R5: `irq` rises on the edge where an operation reaches done, unless control bit 5 is set.
- R6: `irq` is a level. It stays high until a command write with bit 4 or bit 5 set, a soft reset or a hardware reset clears it.
- R7: A command write with bit 6 set has these effects: both operations return to idle, control bits 6, 5 and 4 clear, and `irq` clears.
- R8: A start command for an operation that is running or done restarts it, with the full RUN_CYCLES run length.
- R9: The data port at 0x14 returns the LFSR value, then advances it once with next = (v >> 1) XOR (v[0] ? 0x8020_0003 : 0). The reset value is 0x1ACE_B00C. No other access advances the LFSR.
- R10: Reads of any other offset return 0, and writes to them change nothing.
- R11: Status bits 15:12 and 11:8 always read 5 and bit 6 always reads 1. Bits 7, 3, 2 and 31:16 always read 0.
- R12: `bus_rdata` keeps its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt on operation completion |

## Verification
A stuck or miscounted operation state machine shows up directly in the busy/ready and done bits of the status word. The bench polls that word on every cycle of each run, so a run that is one cycle too long or too short fails on the first status read that disagrees. A wrong interrupt-set or interrupt-clear decision is caught on the `irq` pin within one cycle of the completing edge or of the clearing write. LFSR corruption, or an advance on a read of the wrong offset, appears at the next data-port read.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_DONE = 2'd2
  } op_state_t;

  // operation slots; index equals the command start bit
  localparam int OP_SELFTEST = 0;
  localparam int OP_SEED     = 1;
  localparam int NUM_OPS     = 2;

  // register byte offsets
  localparam logic [7:0] OFS_IDENT  = 8'h00;
  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_CTL    = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_RAND   = 8'h14;

  // command bits
  localparam int CMD_SOFT_RST = 6;
  localparam int CMD_CLR_ERR  = 5;
  localparam int CMD_CLR_IRQ  = 4;

  // control bits
  localparam int CTL_MASK_ERR  = 6;
  localparam int CTL_MASK_DONE = 5;
  localparam int CTL_AUTO_SEED = 4;

  // status bits
  localparam int ST_READY     = 0;
  localparam int ST_BUSY      = 1;
  localparam int ST_TEST_DONE = 4;
  localparam int ST_SEED_DONE = 5;
  localparam int ST_SEED_AVL  = 6;
  localparam int BUF_DEPTH    = 5;

  localparam logic [3:0]  ID_TYPE  = 4'h1;
  localparam logic [7:0]  ID_MAJOR = 8'h02;
  localparam logic [7:0]  ID_MINOR = 8'h40;
  localparam logic [31:0] IDENT_WORD = {ID_TYPE, 12'h000, ID_MAJOR, ID_MINOR};

endpackage

// File: rtl/rng_op_fsm.sv
module rng_op_fsm
  import rng_ctl_pkg::*;
#(
  parameter int RUN_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      soft_rst,
  input  logic      start,
  output op_state_t state_o,
  output logic      done_o
);

  localparam int CNT_W = $clog2(RUN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_CYCLES - 1);

  op_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (state_q == OP_RUN) && (cnt_q == LAST);

  // a start wins over a soft reset in the same write
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= OP_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= OP_RUN;
      cnt_q   <= '0;
    end else if (soft_rst) begin
      state_q <= OP_IDLE;
      cnt_q   <= '0;
    end else if (state_q == OP_RUN) begin
      if (at_last) begin
        state_q <= OP_DONE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign done_o  = at_last && !start && !soft_rst;

  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    (state_q == OP_DONE && $past(state_q) != OP_DONE) |-> $past(state_q) == OP_RUN); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == OP_RUN && cnt_q != LAST && !soft_rst) |=> state_q == OP_RUN); // R8
  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    start |=> (state_q == OP_RUN && cnt_q == '0)); // R8

endmodule

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int           W    = 32,
  parameter logic [W-1:0] POLY = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] value_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_nx;

  assign state_nx = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? POLY : '0);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= state_nx;
  end

  assign value_o = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R9
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state_q)); // R9
  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (rst)
    adv |=> state_q != $past(state_q)); // R9

endmodule

// File: rtl/rng_ctl_top.sv
module rng_ctl_top
  import rng_ctl_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          RUN_CYCLES = 16,
  parameter logic [31:0] LFSR_POLY  = 32'h8020_0003,
  parameter logic [31:0] LFSR_SEED  = 32'h1ACE_B00C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_cmd, wr_ctl, rd_any, rd_rand;
  logic sw_rst, irq_clr;

  assign wr_cmd  = bus_sel && bus_wr && hit(bus_addr, OFS_CMD);
  assign wr_ctl  = bus_sel && bus_wr && hit(bus_addr, OFS_CTL);
  assign rd_any  = bus_sel && !bus_wr;
  assign rd_rand = rd_any && hit(bus_addr, OFS_RAND);
  assign sw_rst  = wr_cmd && bus_wdata[CMD_SOFT_RST];
  assign irq_clr = wr_cmd && (bus_wdata[CMD_CLR_IRQ] || bus_wdata[CMD_CLR_ERR]);

  logic wdata_unused;
  assign wdata_unused = ^{bus_wdata[31:7], bus_wdata[3:2]};

  // operation engines
  logic [NUM_OPS-1:0] op_start, op_done, op_run, op_fin;
  op_state_t          op_state [NUM_OPS];

  assign op_start = {NUM_OPS{wr_cmd}} & bus_wdata[NUM_OPS-1:0];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    rng_op_fsm #(.RUN_CYCLES(RUN_CYCLES)) u_op (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (sw_rst),
      .start    (op_start[g]),
      .state_o  (op_state[g]),
      .done_o   (op_done[g])
    );
    assign op_run[g] = (op_state[g] == OP_RUN);
    assign op_fin[g] = (op_state[g] == OP_DONE);
  end

  // control register
  logic mask_err_q, mask_done_q, auto_seed_q;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      mask_err_q  <= 1'b0;
      mask_done_q <= 1'b0;
      auto_seed_q <= 1'b0;
    end else if (wr_ctl) begin
      mask_err_q  <= bus_wdata[CTL_MASK_ERR];
      mask_done_q <= bus_wdata[CTL_MASK_DONE];
      auto_seed_q <= bus_wdata[CTL_AUTO_SEED];
    end
  end

  // interrupt: a new completion wins over a clear in the same cycle
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)                          irq_q <= 1'b0;
    else if (|op_done && !mask_done_q) irq_q <= 1'b1;
    else if (irq_clr || sw_rst)        irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // random source
  logic [31:0] rnd_val;

  rng_lfsr #(.W(32), .POLY(LFSR_POLY), .SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .adv     (rd_rand),
    .value_o (rnd_val)
  );

  // readback
  logic [31:0] rd_mux, rdata_q;
  logic        busy;

  assign busy = |op_run;

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFS_IDENT)) begin
      rd_mux = IDENT_WORD;
    end else if (hit(bus_addr, OFS_CMD)) begin
      rd_mux[OP_SEED]     = op_run[OP_SEED];
      rd_mux[OP_SELFTEST] = op_run[OP_SELFTEST];
    end else if (hit(bus_addr, OFS_CTL)) begin
      rd_mux[CTL_MASK_ERR]  = mask_err_q;
      rd_mux[CTL_MASK_DONE] = mask_done_q;
      rd_mux[CTL_AUTO_SEED] = auto_seed_q;
    end else if (hit(bus_addr, OFS_STAT)) begin
      rd_mux[15:12]        = 4'(BUF_DEPTH);
      rd_mux[11:8]         = 4'(BUF_DEPTH);
      rd_mux[ST_SEED_AVL]  = 1'b1;
      rd_mux[ST_SEED_DONE] = op_fin[OP_SEED];
      rd_mux[ST_TEST_DONE] = op_fin[OP_SELFTEST];
      rd_mux[ST_BUSY]      = busy;
      rd_mux[ST_READY]     = !busy;
    end else if (hit(bus_addr, OFS_RAND)) begin
      rd_mux = rnd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(irq)) |-> !$past(mask_done_q)); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr && !sw_rst) |=> irq); // R6
  AST_SOFT_RST_CTL: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!mask_err_q && !mask_done_q && !auto_seed_q)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(bus_rdata)); // R12

endmodule

// File: tb/tb_rng_ctl_top.sv
module tb_rng_ctl_top;

  localparam int RUN = 16;
  localparam logic [31:0] SEED_V = 32'h1ACE_B00C;
  localparam logic [31:0] POLY_V = 32'h8020_0003;
  localparam logic [31:0] ST_BASE = 32'h0000_5540;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rng_ctl_top dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] lfsr_step(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? POLY_V : 32'h0);
  endfunction

  function automatic bit mapped(input logic [11:0] a);
    return a == 12'h000 || a == 12'h004 || a == 12'h008 || a == 12'h00C || a == 12'h014;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // each access starts right after a negedge and ends on the next negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    report();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ctl_m;
    logic [31:0] lf_m;
    logic [31:0] last_rd;
    void'($urandom(32'd4711));

    idle(3);
    rst = 1'b0;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    chk(bus_rdata == 32'd0, "R1 rdata", bus_rdata, 32'd0);
    rd(12'h004, v); chk(v == 32'd0, "R1 cmd", v, 32'd0);
    rd(12'h008, v); chk(v == 32'd0, "R1 ctl", v, 32'd0);
    rd(12'h00C, v); chk(v == 32'h5541, "R1 R11 status", v, 32'h5541);
    rd(12'h000, v); chk(v == 32'h1000_0240, "R2 ident", v, 32'h1000_0240);

    // R3 control replacement
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, v); chk(v == 32'h70, "R3 ctl all", v, 32'h70);
    wr(12'h008, 32'h0000_0020);
    rd(12'h008, v); chk(v == 32'h20, "R3 ctl replace", v, 32'h20);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] d;
      d = $urandom;
      wr(12'h008, d);
      rd(12'h008, v); chk(v == (d & 32'h70), "R3 ctl random", v, d & 32'h70);
    end
    wr(12'h008, 32'h0);

    // R4 R5 self-test run with interrupt enabled
    wr(12'h004, 32'h1);
    for (int i = 0; i <= RUN; i++) begin
      if (i == 0) begin
        rd(12'h004, v); chk(v == 32'h1, "R4 cmd running", v, 32'h1);
      end else if (i < RUN) begin
        rd(12'h00C, v); chk(v == (ST_BASE | 32'h2), "R4 busy", v, ST_BASE | 32'h2);
      end else begin
        rd(12'h00C, v); chk(v == (ST_BASE | 32'h11), "R4 test done", v, ST_BASE | 32'h11);
      end
      chk(irq == (i >= RUN - 1), "R5 irq timing", {31'd0, irq}, {31'd0, i >= RUN - 1});
    end

    // R6 level then clear via bit 4
    idle(5);
    chk(irq == 1'b1, "R6 irq holds", {31'd0, irq}, 32'd1);
    wr(12'h004, 32'h10);
    chk(irq == 1'b0, "R6 clear bit4", {31'd0, irq}, 32'd0);

    // R5 masked seed completion
    wr(12'h008, 32'h20);
    wr(12'h004, 32'h2);
    idle(RUN + 2);
    rd(12'h00C, v); chk(v == (ST_BASE | 32'h31), "R4 seed done", v, ST_BASE | 32'h31);
    chk(irq == 1'b0, "R5 masked", {31'd0, irq}, 32'd0);

    // R8 restart from done, R6 clear via bit 5
    wr(12'h008, 32'h0);
    wr(12'h004, 32'h2);
    rd(12'h00C, v); chk(v == (ST_BASE | 32'h12), "R8 restart from done", v, ST_BASE | 32'h12);
    idle(RUN);
    chk(irq == 1'b1, "R5 unmasked seed irq", {31'd0, irq}, 32'd1);
    wr(12'h004, 32'h20);
    chk(irq == 1'b0, "R6 clear bit5", {31'd0, irq}, 32'd0);

    // R8 restart while running
    wr(12'h004, 32'h1);
    idle(7);
    wr(12'h004, 32'h1);
    for (int i = 0; i <= RUN; i++) begin
      rd(12'h00C, v);
      if (i < RUN) chk(v == (ST_BASE | 32'h22), "R8 busy after restart", v, ST_BASE | 32'h22);
      else         chk(v == (ST_BASE | 32'h31), "R8 done after restart", v, ST_BASE | 32'h31);
      if (i == RUN - 2) chk(irq == 1'b0, "R8 no early irq", {31'd0, irq}, 32'd0);
    end
    chk(irq == 1'b1, "R5 irq after restart", {31'd0, irq}, 32'd1);

    // R7 soft reset
    wr(12'h008, 32'h70);
    wr(12'h004, 32'h40);
    chk(irq == 1'b0, "R7 irq", {31'd0, irq}, 32'd0);
    rd(12'h008, v); chk(v == 32'd0, "R7 ctl", v, 32'd0);
    rd(12'h00C, v); chk(v == 32'h5541, "R7 status", v, 32'h5541);
    rd(12'h004, v); chk(v == 32'd0, "R7 cmd", v, 32'd0);

    // R9 R10 R11 R12 random mix
    ctl_m = 32'd0;
    lf_m  = SEED_V;
    rd(12'h014, v); chk(v == lf_m, "R9 first word", v, lf_m);
    lf_m = lfsr_step(lf_m);
    last_rd = v;
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [11:0] a;
      logic [31:0] d;
      op = int'($urandom % 6);
      case (op)
        0, 1: begin
          rd(12'h014, v); chk(v == lf_m, "R9 random word", v, lf_m);
          lf_m = lfsr_step(lf_m);
        end
        2: begin
          d = $urandom;
          wr(12'h008, d); ctl_m = d & 32'h70;
          rd(12'h008, v); chk(v == ctl_m, "R3 ctl mix", v, ctl_m);
        end
        3: begin
          do a = 12'($urandom) & 12'hFFC; while (mapped(a));
          rd(a, v); chk(v == 32'd0, "R10 unmapped read", v, 32'd0);
        end
        4: begin
          do a = 12'($urandom) & 12'hFFC; while (mapped(a));
          wr(a, 32'hFFFF_FFFF);
          rd(12'h00C, v); chk(v == 32'h5541, "R10 R11 status after unmapped write", v, 32'h5541);
          rd(12'h008, v); chk(v == ctl_m, "R10 ctl after unmapped write", v, ctl_m);
          chk(irq == 1'b0, "R10 irq", {31'd0, irq}, 32'd0);
        end
        default: begin
          idle(int'($urandom % 4) + 1);
          chk(bus_rdata == last_rd, "R12 rdata hold", bus_rdata, last_rd);
        end
      endcase
      last_rd = v;
    end
    rd(12'h014, v); chk(v == lf_m, "R9 final word", v, lf_m);

    report();
  end

endmodule